// File: doc/BRIEF.md
# Process-Tagged Variable-Page Address Translation Buffer

This block translates a 32-bit effective address into a 32-bit physical address. It searches a small, fully associative table of translations, and every search takes the current 8-bit process identifier into account. A stored translation matches only when two things agree: its process tag equals the requesting identifier, and its effective page number equals the page-number bits of the request. Each entry carries its own page-size code, so the split between the translated page-number bits and the untranslated offset bits is set per entry. Pages run from 1 kB to 16 MB in steps of four.

Software keeps the full translation table in memory and loads chosen translations into the buffer through an indexed write port. The block never fetches entries by itself. When no held entry matches, it only reports a miss, and software must then refill the buffer. An invalidate-all input empties the buffer in one cycle, for example on an address-space switch.

The search itself is combinational and the result is registered. Hit, miss and the physical address therefore appear one cycle after the request.

Top module: `ptlb_xlate`

## Requirements
- R1: After a synchronous active-high reset, every entry is invalid, all response outputs are zero, and the first lookup misses.
- R2: With `wr_en` high, the entry selected by `wr_idx` takes all of its fields in one clock edge. A lookup in the same cycle still sees the old contents. A lookup in the next cycle sees the new contents.
- R3: A hit requires a valid entry whose 8-bit process tag equals `req_pid` and whose page number matches. The same effective address presented with a different identifier misses.
- R4: Size code c (0 to 7) gives an offset of 10+2c bits: 0 is 1 kB, 1 is 4 kB, and so on up to 7, which is 16 MB. The stored page-number field holds address bits 31:10, and its lowest 2c bits are left out of the comparison.
- R5: On a hit, physical address bits below 10+2c equal the request address bits. The bits above come from the stored physical page-number field, which supplies address bits 31:10.
- R6: `rsp_valid` is high exactly one cycle after `req_valid`. In a cycle without a request response, `rsp_valid`, `rsp_hit` and `rsp_miss` are low and `rsp_pa` is zero.
- R7: When no valid entry matches, `rsp_miss` is high and `rsp_pa` is zero.
- R8: If several entries match, the entry with the lowest index supplies the translation.
- R9: `inv_all` clears every valid bit at the next clock edge. It takes priority over a write in the same cycle.
- R10: During a response exactly one of `rsp_hit` and `rsp_miss` is high. Neither is high without `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address to translate |
| req_pid | input | 8 | Current process identifier |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_valid | input | 1 | Valid bit for the written entry |
| wr_pid | input | 8 | Process tag for the written entry |
| wr_size | input | 3 | Page-size code for the written entry |
| wr_epn | input | 22 | Effective page number (address bits 31:10) |
| wr_ppn | input | 22 | Physical page number (address bits 31:10) |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No translation found |
| rsp_pa | output | 32 | Physical address, zero on miss |

## Verification
A corrupted entry, or a wrong size mask, shows up at the very next lookup that touches that page. The symptom is a miss where a hit was due, a hit under the wrong process identifier, or wrong address bits just above the offset boundary. A fault in the priority logic only appears when two entries overlap. The bench therefore sets up nested large and small pages and checks which physical page comes back one cycle after the request. Stale valid bits after an invalidate show up as hits on the first lookup that follows it.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    localparam int VA_W    = 32;
    localparam int PID_W   = 8;
    localparam int MIN_OFF = 10;
    localparam int PN_W    = VA_W - MIN_OFF;
    localparam int SZ_W    = 3;
    localparam int SZ_STEP = 2;

    typedef struct packed {
        logic              vld;
        logic [PID_W-1:0]  pid;
        logic [SZ_W-1:0]   sz;
        logic [PN_W-1:0]   epn;
        logic [PN_W-1:0]   ppn;
    } tlb_ent_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              miss;
        logic [VA_W-1:0]   pa;
    } tlb_rsp_t;

    // ones on the untranslated offset bits for a given size code
    function automatic logic [VA_W-1:0] off_mask(input logic [SZ_W-1:0] sz);
        logic [VA_W-1:0] m;
        m = '0;
        for (int b = 0; b < VA_W; b++) begin
            if (b < MIN_OFF + SZ_STEP * int'(sz)) m[b] = 1'b1;
        end
        return m;
    endfunction

    // ones on the page-number field bits that take part in the compare
    function automatic logic [PN_W-1:0] pn_cmp_mask(input logic [SZ_W-1:0] sz);
        logic [PN_W-1:0] m;
        m = '0;
        for (int b = 0; b < PN_W; b++) begin
            if (b >= SZ_STEP * int'(sz)) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ptlb_entry_store.sv
module ptlb_entry_store
    import ptlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inv_all,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_ent_t         wr_ent,
    output tlb_ent_t         ents [N_ENT]
);

    tlb_ent_t mem [N_ENT];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENT; i++) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (inv_all) begin
                mem[i].vld <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                mem[i] <= wr_ent;
            end
        end
    end

    logic [N_ENT-1:0] vld_vec;
    for (genvar g = 0; g < N_ENT; g++) begin : g_out
        assign ents[g]    = mem[g];
        assign vld_vec[g] = mem[g].vld;
    end

    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (vld_vec == '0)); // R9

    AST_WR_LOADS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !inv_all) |=> (ents[$past(wr_idx)] == $past(wr_ent))); // R2

endmodule

// File: rtl/ptlb_match.sv
module ptlb_match
    import ptlb_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  tlb_ent_t          ents [N_ENT],
    input  logic [VA_W-1:0]   ea,
    input  logic [PID_W-1:0]  pid,
    output logic [N_ENT-1:0]  hit_vec
);

    logic [PN_W-1:0] ea_pn;
    assign ea_pn = ea[VA_W-1:MIN_OFF];

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic pn_eq;
        logic pid_eq;
        assign pn_eq  = ((ents[g].epn ^ ea_pn) & pn_cmp_mask(ents[g].sz)) == '0;
        assign pid_eq = (ents[g].pid == pid);
        assign hit_vec[g] = ents[g].vld && pid_eq && pn_eq;
    end

endmodule

// File: rtl/ptlb_prio_sel.sv
module ptlb_prio_sel
    import ptlb_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  tlb_ent_t          ents [N_ENT],
    input  logic [N_ENT-1:0]  hit_vec,
    input  logic [VA_W-1:0]   ea,
    output logic              any_hit,
    output logic [N_ENT-1:0]  sel_oh,
    output logic [SZ_W-1:0]   sel_sz,
    output logic [VA_W-1:0]   pa
);

    tlb_ent_t        win;
    logic [VA_W-1:0] om;

    always_comb begin
        win     = '0;
        sel_oh  = '0;
        any_hit = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit_vec[i] && !any_hit) begin
                any_hit   = 1'b1;
                sel_oh[i] = 1'b1;
                win       = ents[i];
            end
        end
    end

    assign sel_sz = win.sz;
    assign om     = off_mask(win.sz);
    assign pa     = ({win.ppn, {MIN_OFF{1'b0}}} & ~om) | (ea & om);

endmodule

// File: rtl/ptlb_xlate.sv
module ptlb_xlate
    import ptlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [31:0]         req_ea,
    input  logic [7:0]          req_pid,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_valid,
    input  logic [7:0]          wr_pid,
    input  logic [2:0]          wr_size,
    input  logic [21:0]         wr_epn,
    input  logic [21:0]         wr_ppn,
    input  logic                inv_all,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic [31:0]         rsp_pa
);

    tlb_ent_t         wr_ent;
    tlb_ent_t         ents [N_ENT];
    logic [N_ENT-1:0] hit_vec;
    logic [N_ENT-1:0] sel_oh;
    logic [SZ_W-1:0]  sel_sz;
    logic             any_hit;
    logic [VA_W-1:0]  pa_c;
    tlb_rsp_t         rsp_q;

    assign wr_ent = '{vld: wr_valid, pid: wr_pid, sz: wr_size, epn: wr_epn, ppn: wr_ppn};

    ptlb_entry_store #(.N_ENT(N_ENT)) u_store (
        .clk     (clk),
        .rst     (rst),
        .inv_all (inv_all),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_ent  (wr_ent),
        .ents    (ents)
    );

    ptlb_match #(.N_ENT(N_ENT)) u_match (
        .ents    (ents),
        .ea      (req_ea),
        .pid     (req_pid),
        .hit_vec (hit_vec)
    );

    ptlb_prio_sel #(.N_ENT(N_ENT)) u_sel (
        .ents    (ents),
        .hit_vec (hit_vec),
        .ea      (req_ea),
        .any_hit (any_hit),
        .sel_oh  (sel_oh),
        .sel_sz  (sel_sz),
        .pa      (pa_c)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= 1'b1;
            rsp_q.hit   <= any_hit;
            rsp_q.miss  <= !any_hit;
            rsp_q.pa    <= any_hit ? pa_c : '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_pa    = rsp_q.pa;

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && rsp_pa == '0)); // R6

    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit ^ rsp_miss)); // R10

    AST_MISS_PA_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_pa == '0)); // R7

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        (hit_vec & (sel_oh - N_ENT'(1))) == '0); // R8

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && any_hit) |=>
            (((rsp_pa ^ $past(req_ea)) & off_mask($past(sel_sz))) == '0)); // R5

endmodule

// File: tb/sim_ptlb_xlate.sv
`timescale 1ns/1ps
module sim_ptlb_xlate;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_ea;
    logic [7:0]  req_pid;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic        wr_valid;
    logic [7:0]  wr_pid;
    logic [2:0]  wr_size;
    logic [21:0] wr_epn;
    logic [21:0] wr_ppn;
    logic        inv_all;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_miss;
    logic [31:0] rsp_pa;

    always #5 clk = ~clk;

    ptlb_xlate u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea), .req_pid(req_pid),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_pid(wr_pid),
        .wr_size(wr_size), .wr_epn(wr_epn), .wr_ppn(wr_ppn), .inv_all(inv_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa)
    );

    int total = 0;
    int bad   = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    logic [33:0] exp_q [$];
    string       tag_q [$];

    // reference table kept by the bench
    logic        m_vld [16];
    logic [7:0]  m_pid [16];
    logic [2:0]  m_sz  [16];
    logic [21:0] m_epn [16];
    logic [21:0] m_ppn [16];

    function automatic logic [33:0] predict(input logic [31:0] ea, input logic [7:0] pid);
        for (int i = 0; i < 16; i++) begin
            int sh;
            logic [31:0] om;
            sh = 2 * int'(m_sz[i]);
            om = (32'd1 << (10 + sh)) - 32'd1;
            if (m_vld[i] && m_pid[i] == pid && ((m_epn[i] ^ ea[31:10]) >> sh) == 22'd0)
                return {1'b1, 1'b0, ({m_ppn[i], 10'd0} & ~om) | (ea & om)};
        end
        return {1'b0, 1'b1, 32'd0};
    endfunction

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual hit=%0b miss=%0b pa=%08h expected hit=%0b miss=%0b pa=%08h",
                     tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic quiet_inputs();
        req_valid = 1'b0; wr_en = 1'b0; inv_all = 1'b0;
    endtask

    task automatic model_write(input int idx, input logic v, input logic [7:0] p,
                               input logic [2:0] s, input logic [21:0] e, input logic [21:0] q);
        m_vld[idx] = v; m_pid[idx] = p; m_sz[idx] = s; m_epn[idx] = e; m_ppn[idx] = q;
    endtask

    task automatic drive_write(input int idx, input logic v, input logic [7:0] p,
                               input logic [2:0] s, input logic [21:0] e, input logic [21:0] q);
        wr_en = 1'b1; wr_idx = idx[3:0]; wr_valid = v; wr_pid = p; wr_size = s;
        wr_epn = e; wr_ppn = q;
    endtask

    task automatic do_write(input int idx, input logic v, input logic [7:0] p,
                            input logic [2:0] s, input logic [21:0] e, input logic [21:0] q);
        @(negedge clk);
        quiet_inputs();
        drive_write(idx, v, p, s, e, q);
        model_write(idx, v, p, s, e, q);
    endtask

    task automatic do_lookup(input logic [31:0] ea, input logic [7:0] pid, input string tag);
        @(negedge clk);
        quiet_inputs();
        req_valid = 1'b1; req_ea = ea; req_pid = pid;
        exp_q.push_back(predict(ea, pid));
        tag_q.push_back(tag);
    endtask

    // R2: write and lookup in one cycle; the lookup must see the old table
    task automatic do_write_and_lookup(input int idx, input logic [7:0] p, input logic [2:0] s,
                                       input logic [21:0] e, input logic [21:0] q,
                                       input logic [31:0] ea, input string tag);
        @(negedge clk);
        quiet_inputs();
        req_valid = 1'b1; req_ea = ea; req_pid = p;
        exp_q.push_back(predict(ea, p));
        tag_q.push_back(tag);
        drive_write(idx, 1'b1, p, s, e, q);
        model_write(idx, 1'b1, p, s, e, q);
    endtask

    task automatic do_idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            quiet_inputs();
        end
    endtask

    // monitor: pops the scoreboard as responses arrive
    always @(negedge clk) begin
        if (mon_on) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R6: actual unexpected response expected none");
                end else begin
                    logic [33:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {rsp_hit, rsp_miss, rsp_pa}, e);
                end
            end else begin
                check("R6 idle", {rsp_hit, rsp_miss, rsp_pa}, 34'd0);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model_write(i, 1'b0, 8'd0, 3'd0, 22'd0, 22'd0);
        rst = 1'b1;
        quiet_inputs();
        req_ea = '0; req_pid = '0; wr_idx = '0; wr_valid = 1'b0; wr_pid = '0;
        wr_size = '0; wr_epn = '0; wr_ppn = '0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {rsp_valid, rsp_hit, rsp_miss, rsp_pa}, 35'd0);
        rst = 1'b0;
        mon_on = 1'b1;

        // R1: empty table misses
        do_lookup(32'h0000_0000, 8'd0, "R1 first lookup");
        do_lookup(32'h1234_5678, 8'd5, "R1 empty table");

        // R3 R4 R5: 4 kB page, tag 5
        do_write(3, 1'b1, 8'd5, 3'd1, 22'(32'h1234_5000 >> 10), 22'(32'hABCD_E000 >> 10));
        do_lookup(32'h1234_5678, 8'd5, "R5 4k hit");
        do_lookup(32'h1234_5FFF, 8'd5, "R4 4k top offset");
        do_lookup(32'h1234_6000, 8'd5, "R4 4k next page");
        do_lookup(32'h1234_5678, 8'd6, "R3 wrong pid");
        do_idle(2);

        // R3: same address, other process, other translation
        do_write(4, 1'b1, 8'd6, 3'd1, 22'(32'h1234_5000 >> 10), 22'(32'h0007_7000 >> 10));
        do_lookup(32'h1234_5678, 8'd6, "R3 overlap pid 6");
        do_lookup(32'h1234_5678, 8'd5, "R3 overlap pid 5");

        // R4: 16 MB and 1 kB pages
        do_write(5, 1'b1, 8'd1, 3'd7, 22'(32'h4700_0000 >> 10), 22'(32'h9C00_0000 >> 10));
        do_write(0, 1'b1, 8'd2, 3'd0, 22'(32'h0000_0400 >> 10), 22'(32'h8000_0C00 >> 10));
        do_lookup(32'h47AB_CDEF, 8'd1, "R4 16M hit");
        do_lookup(32'h48AB_CDEF, 8'd1, "R4 16M outside");
        do_lookup(32'h0000_07FF, 8'd2, "R4 1k hit");
        do_lookup(32'h0000_0800, 8'd2, "R4 1k next page");
        do_write(6, 1'b1, 8'd3, 3'd4, 22'(32'h0120_0000 >> 10), 22'(32'h5550_0000 >> 10));
        do_lookup(32'h0123_4567, 8'd3, "R4 256k hit");

        // R8: nested pages, lowest index wins
        do_write(10, 1'b1, 8'd9, 3'd5, 22'(32'h2000_0000 >> 10), 22'(32'h3000_0000 >> 10));
        do_write(8,  1'b1, 8'd9, 3'd1, 22'(32'h2004_5000 >> 10), 22'(32'h6600_1000 >> 10));
        do_lookup(32'h2004_5123, 8'd9, "R8 overlap low index");
        do_lookup(32'h2004_6123, 8'd9, "R8 large page only");
        do_write(8, 1'b0, 8'd9, 3'd1, 22'(32'h2004_5000 >> 10), 22'(32'h6600_1000 >> 10));
        do_lookup(32'h2004_5123, 8'd9, "R8 low entry invalid");

        // R2: same-cycle write and lookup, then the next lookup
        do_write_and_lookup(12, 8'd7, 3'd2, 22'(32'h7770_0000 >> 10), 22'(32'h1110_0000 >> 10),
                            32'h7770_1234, "R2 same cycle old");
        do_lookup(32'h7770_1234, 8'd7, "R2 next cycle new");

        // R9: invalidate together with a write
        @(negedge clk);
        quiet_inputs();
        inv_all = 1'b1;
        drive_write(1, 1'b1, 8'd4, 3'd1, 22'(32'h0404_0000 >> 10), 22'(32'h0808_0000 >> 10));
        for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
        do_lookup(32'h0404_0010, 8'd4, "R9 write dropped");
        do_lookup(32'h1234_5678, 8'd5, "R9 cleared 4k");
        do_lookup(32'h47AB_CDEF, 8'd1, "R9 cleared 16M");
        do_idle(3);

        // R3 R4 R5 R7 R8: random mix
        for (int n = 0; n < 400; n++) begin
            int          idx;
            logic [31:0] ea;
            logic [7:0]  pid;
            idx = int'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) begin
                do_write(idx, ($urandom_range(0, 5) != 0), 8'($urandom_range(0, 3)),
                         3'($urandom_range(0, 7)), 22'($urandom), 22'($urandom));
            end else begin
                ea  = {m_epn[idx], 10'd0} ^ ($urandom & 32'h00FF_FFFF & {32{($urandom_range(0, 1) == 1)}})
                      ^ 32'($urandom_range(0, 1023));
                pid = ($urandom_range(0, 4) == 0) ? 8'($urandom_range(0, 3)) : m_pid[idx];
                do_lookup(ea, pid, "R7 R8 random lookup");
            end
        end

        do_idle(4);
        mon_on = 1'b0;
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R6: actual %0d responses missing expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule